// File: doc/BRIEF.md
# Watchpoint Address Range Decoder

This block turns a programmed watch value word and a watch control word into a decoded byte range and an access-type filter. It then checks every data access presented on its access port against that range. An access is a byte address, a size and a read/write flag. When any byte of an accepted access lands inside the range, the block raises a registered hit together with a flag saying whether the access was a write.

The range comes from one of two forms. In mask form, a 5-bit exponent gives a power-of-two length, and the base is aligned down to that length. In byte-select form, an 8-bit lane pattern is read as follows: its lowest set bit gives the start offset from the word-aligned value, and the run of ones from that bit gives the length. Accesses made in legacy big-endian mode have their low address bits swizzled before the comparison.

A small controller sequences the block. It has three states:

- **ST_IDLE**: the watchpoint is disarmed.
- **ST_DECODE**: a one-cycle state entered on any register write. In this cycle the stored words are decoded into range registers.
- **ST_ARMED**: the decoded watchpoint is live.

The transitions are:

- **cfg-write**: any state goes to ST_DECODE.
- **decode-live**: ST_DECODE goes to ST_ARMED.
- **decode-dead**: ST_DECODE goes to ST_IDLE.

Top module: `wpt_range_match`

## Requirements
- R1: A write to the value word (`cfg_sel`=0) stores it with bits 1:0 forced to zero, so a byte-select watch built on value 0x4003 starts at 0x4000.
- R2: The watchpoint never hits when the enable bit (control bit 0) is clear or when the access-type field (control bits 4:3) is 0.
- R3: Access-type field value 1 hits only on reads, value 2 only on writes, and value 3 on both.
- R4: A mask exponent (control bits 28:24) of 1 or 2 disables the watchpoint.
- R5: A mask exponent m of 3 or more gives a range of length 2^m whose base is the stored value aligned down to 2^m.
- R6: With mask exponent 0, the byte-select field (control bits 12:5) is used. When bit 2 of the stored value is set, only the low four select bits are kept. A resulting select of zero disables the watchpoint.
- R7: In byte-select form, the range starts at the word-aligned value plus the number of trailing zeros of the select. Its length is the count of consecutive ones from that bit, and set bits beyond the first run are ignored.
- R8: When `acc_big_endian` is high, the access address is XORed with 3 for byte accesses and with 2 for halfword accesses before comparison. Word and doubleword accesses are unchanged.
- R9: An access of 2^`acc_size` bytes hits when any of its bytes lies in [base, base+length).
- R10: `hit_write` is high only with `hit` and equals the write flag of the access that caused the hit.
- R11: `hit` is registered and appears in the cycle after the access is sampled. No hit is raised for an access sampled in the same cycle as a register write or in the following decode cycle.
- R12: After reset, `hit` and `hit_write` are low and the watchpoint is disarmed until it is configured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects the value word, 1 the control word |
| cfg_wdata | input | AW | Register write data |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | AW | Access byte address |
| acc_size | input | 2 | log2 of access size in bytes |
| acc_write | input | 1 | 1 for a store, 0 for a load |
| acc_big_endian | input | 1 | Legacy big-endian lane adjustment enable |
| hit | output | 1 | Registered watchpoint hit |
| hit_write | output | 1 | Hit was caused by a write |

## Verification
The checker assumes that the inputs are settled at each rising edge. It also assumes that reset is held long enough for the access and configuration strobes to be low when it is released. The bench drives every input on the falling edge and holds all strobes low during reset.

Random configurations keep the value word near one region of memory, with mask exponents up to 12. This lets random accesses regularly straddle both range edges while the arithmetic stays well clear of address wrap-around, which the properties never have to consider.

// File: rtl/wpt_pkg.sv
package wpt_pkg;
    typedef enum logic [1:0] {ST_IDLE, ST_DECODE, ST_ARMED} wpt_state_e;

    localparam int CTL_EN_BIT = 0;
    localparam int CTL_LSC_LO = 3;
    localparam int CTL_SEL_LO = 5;
    localparam int CTL_MSK_LO = 24;
    localparam int SEL_W      = 8;
    localparam int MSK_W      = 5;

    localparam logic [1:0] LSC_LOAD  = 2'd1;
    localparam logic [1:0] LSC_STORE = 2'd2;
endpackage

// File: rtl/wpt_cfg_regs.sv
module wpt_cfg_regs
    import wpt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic                sel,
    input  logic [AW-1:0]       wdata,
    output logic [AW-1:0]       value_q,
    output logic                en_q,
    output logic [1:0]          lsc_q,
    output logic [SEL_W-1:0]    bsel_q,
    output logic [MSK_W-1:0]    msk_q
);
    logic unused_wdata;
    assign unused_wdata = ^wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            value_q <= '0;
            en_q    <= 1'b0;
            lsc_q   <= '0;
            bsel_q  <= '0;
            msk_q   <= '0;
        end else if (we) begin
            if (!sel) begin
                value_q <= {wdata[AW-1:2], 2'b00};
            end else begin
                en_q   <= wdata[CTL_EN_BIT];
                lsc_q  <= wdata[CTL_LSC_LO +: 2];
                bsel_q <= wdata[CTL_SEL_LO +: SEL_W];
                msk_q  <= wdata[CTL_MSK_LO +: MSK_W];
            end
        end
    end
endmodule

// File: rtl/wpt_decode.sv
module wpt_decode
    import wpt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0]    value,
    input  logic             en,
    input  logic [1:0]       lsc,
    input  logic [SEL_W-1:0] bsel,
    input  logic [MSK_W-1:0] msk,
    output logic             active,
    output logic             on_load,
    output logic             on_store,
    output logic [AW-1:0]    base,
    output logic [AW:0]      len
);
    localparam logic [AW:0] ONE = {{AW{1'b0}}, 1'b1};

    logic [SEL_W-1:0] eff_sel;
    logic [AW-1:0]    start;
    logic [AW:0]      run_len;
    logic             found;
    logic             in_run;
    logic [AW:0]      pow_len;

    always_comb begin
        eff_sel = value[2] ? (bsel & SEL_W'(4'hF)) : bsel;
        start   = '0;
        run_len = '0;
        found   = 1'b0;
        in_run  = 1'b0;
        for (int i = 0; i < SEL_W; i++) begin
            if (!found && eff_sel[i]) begin
                found  = 1'b1;
                in_run = 1'b1;
                start  = AW'(i);
            end
            if (in_run) begin
                if (eff_sel[i]) run_len = run_len + ONE;
                else            in_run  = 1'b0;
            end
        end
    end

    assign pow_len  = ONE << msk;
    assign on_load  = lsc[0];
    assign on_store = lsc[1];

    always_comb begin
        active = en && (lsc != 2'd0);
        base   = value;
        len    = '0;
        if (msk == MSK_W'(1) || msk == MSK_W'(2)) begin
            active = 1'b0;
        end else if (msk != '0) begin
            len  = pow_len;
            base = value & ~(pow_len[AW-1:0] - AW'(1));
        end else begin
            if (!found) active = 1'b0;
            len  = run_len;
            base = value + start;
        end
    end
endmodule

// File: rtl/wpt_access_cmp.sv
module wpt_access_cmp #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] base,
    input  logic [AW:0]   len,
    input  logic [AW-1:0] addr,
    input  logic [1:0]    size,
    input  logic          big_endian,
    output logic          overlap
);
    logic [AW-1:0] adj;
    logic [AW:0]   acc_lo, acc_hi, win_lo, win_hi;

    always_comb begin
        adj = addr;
        if (big_endian) begin
            unique case (size)
                2'd0:    adj = addr ^ AW'(3);
                2'd1:    adj = addr ^ AW'(2);
                default: adj = addr;
            endcase
        end
    end

    assign acc_lo  = {1'b0, adj};
    assign acc_hi  = acc_lo + ({{AW{1'b0}}, 1'b1} << size);
    assign win_lo  = {1'b0, base};
    assign win_hi  = win_lo + len;
    assign overlap = (acc_lo < win_hi) && (win_lo < acc_hi);
endmodule

// File: rtl/wpt_range_match.sv
module wpt_range_match
    import wpt_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          acc_valid,
    input  logic [AW-1:0] acc_addr,
    input  logic [1:0]    acc_size,
    input  logic          acc_write,
    input  logic          acc_big_endian,
    output logic          hit,
    output logic          hit_write
);
    wpt_state_e state_q;

    logic [AW-1:0]    value_q;
    logic             en_q;
    logic [1:0]       lsc_q;
    logic [SEL_W-1:0] bsel_q;
    logic [MSK_W-1:0] msk_q;

    logic          d_active, d_load, d_store;
    logic [AW-1:0] d_base;
    logic [AW:0]   d_len;

    logic          r_load, r_store;
    logic [AW-1:0] r_base;
    logic [AW:0]   r_len;
    logic          overlap;
    logic          take;

    wpt_cfg_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .value_q(value_q), .en_q(en_q), .lsc_q(lsc_q), .bsel_q(bsel_q), .msk_q(msk_q)
    );

    wpt_decode #(.AW(AW)) u_dec (
        .value(value_q), .en(en_q), .lsc(lsc_q), .bsel(bsel_q), .msk(msk_q),
        .active(d_active), .on_load(d_load), .on_store(d_store),
        .base(d_base), .len(d_len)
    );

    wpt_access_cmp #(.AW(AW)) u_cmp (
        .base(r_base), .len(r_len), .addr(acc_addr), .size(acc_size),
        .big_endian(acc_big_endian), .overlap(overlap)
    );

    // state register and decoded range capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            r_load  <= 1'b0;
            r_store <= 1'b0;
            r_base  <= '0;
            r_len   <= '0;
        end else if (cfg_we) begin
            state_q <= ST_DECODE;
        end else begin
            unique case (state_q)
                ST_DECODE: begin
                    state_q <= d_active ? ST_ARMED : ST_IDLE;
                    r_load  <= d_load;
                    r_store <= d_store;
                    r_base  <= d_base;
                    r_len   <= d_len;
                end
                ST_ARMED: state_q <= ST_ARMED;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    assign take = (state_q == ST_ARMED) && !cfg_we && acc_valid && overlap &&
                  (acc_write ? r_store : r_load);

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hit       <= 1'b0;
            hit_write <= 1'b0;
        end else begin
            hit       <= take;
            hit_write <= take && acc_write;
        end
    end
endmodule

// File: rtl/wpt_range_match_chk.sv
module wpt_range_match_chk (
    input logic clk,
    input logic rst_n,
    input logic cfg_we,
    input logic acc_valid,
    input logic acc_write,
    input logic hit,
    input logic hit_write
);
    AST_HIT_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(acc_valid)); // R11
    AST_CFG_MASKS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we) |-> !hit); // R11
    AST_DECODE_MASKS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we, 2) |-> !hit); // R11
    AST_HIT_WRITE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (hit_write == $past(acc_write))); // R10
    AST_WRITE_FLAG_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        hit_write |-> hit); // R10
endmodule

bind wpt_range_match wpt_range_match_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .acc_valid(acc_valid),
    .acc_write(acc_write), .hit(hit), .hit_write(hit_write)
);

// File: tb/wpt_range_match_tb.sv
module wpt_range_match_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_write = 1'b0, acc_big_endian = 1'b0;
    logic        hit, hit_write;

    int checks = 0, fails = 0;
    logic [31:0] m_val = '0, m_ctl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wpt_range_match #(.AW(32)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .acc_valid(acc_valid), .acc_addr(acc_addr), .acc_size(acc_size),
        .acc_write(acc_write), .acc_big_endian(acc_big_endian),
        .hit(hit), .hit_write(hit_write)
    );

    function automatic logic [31:0] mk_ctl(bit en, bit [1:0] lsc, bit [7:0] bsel, bit [4:0] msk);
        return (32'(msk) << 24) | (32'(bsel) << 5) | (32'(lsc) << 3) | 32'(en);
    endfunction

    function automatic bit model_hit(logic [31:0] val, logic [31:0] ctl, logic [31:0] addr,
                                     logic [1:0] sz, logic wr, logic be);
        longint v, b, l, a, n;
        bit [7:0] s;
        bit [4:0] m;
        int st;
        v = longint'(val & 32'hFFFF_FFFC);
        m = ctl[28:24];
        if (!ctl[0] || ctl[4:3] == 2'd0) return 0;
        if (wr ? !ctl[4] : !ctl[3]) return 0;
        if (m == 5'd1 || m == 5'd2) return 0;
        if (m != 0) begin
            l = longint'(1) << m;
            b = v & ~(l - 1);
        end else begin
            s = ctl[12:5];
            if (v[2]) s = s & 8'h0F;
            if (s == 0) return 0;
            st = 0;
            while (!s[st]) st++;
            l = 0;
            for (int i = st; i < 8 && s[i]; i++) l++;
            b = v + st;
        end
        a = longint'(addr);
        if (be && sz == 2'd0) a = a ^ 3;
        if (be && sz == 2'd1) a = a ^ 2;
        n = longint'(1) << sz;
        return (a < b + l) && (b < a + n);
    endfunction

    task automatic write_reg(bit sel, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        if (sel) m_ctl = d; else m_val = d;
    endtask

    task automatic configure(logic [31:0] v, logic [31:0] c);
        write_reg(1'b0, v);
        write_reg(1'b1, c);
        @(negedge clk);
    endtask

    task automatic check_access(logic [31:0] a, logic [1:0] sz, logic wr, logic be,
                                bit exp, string req);
        acc_valid = 1'b1; acc_addr = a; acc_size = sz; acc_write = wr; acc_big_endian = be;
        @(negedge clk);
        acc_valid = 1'b0;
        checks++;
        if (hit !== exp || hit_write !== (exp && wr)) begin
            fails++;
            $display("FAIL %s addr=%h sz=%0d wr=%0b be=%0b hit=%b/%b expected %b/%b",
                     req, a, sz, wr, be, hit, hit_write, exp, exp && wr);
        end
    endtask

    task automatic model_access(logic [31:0] a, logic [1:0] sz, logic wr, logic be, string req);
        check_access(a, sz, wr, be, model_hit(m_val, m_ctl, a, sz, wr, be), req);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        checks++;
        if (hit !== 1'b0 || hit_write !== 1'b0) begin
            fails++;
            $display("FAIL R12 reset outputs %b%b expected 00", hit, hit_write);
        end
        rst_n = 1'b1;
        @(negedge clk);
        check_access(32'h0, 2'd3, 1'b0, 1'b0, 1'b0, "R12");

        // R1: low value bits dropped
        configure(32'h4003, mk_ctl(1, 3, 8'h01, 0));
        check_access(32'h4000, 2'd0, 1'b0, 1'b0, 1'b1, "R1");
        check_access(32'h4003, 2'd0, 1'b0, 1'b0, 1'b0, "R1");
        // R8: big-endian byte lane swap
        check_access(32'h4003, 2'd0, 1'b1, 1'b1, 1'b1, "R8");
        check_access(32'h4002, 2'd1, 1'b0, 1'b1, 1'b1, "R8");
        check_access(32'h4004, 2'd2, 1'b0, 1'b1, 1'b0, "R8");
        // R10: write flag
        check_access(32'h4000, 2'd2, 1'b1, 1'b0, 1'b1, "R10");
        // R2: enable clear / type zero
        configure(32'h4000, mk_ctl(0, 3, 8'hFF, 0));
        check_access(32'h4000, 2'd3, 1'b0, 1'b0, 1'b0, "R2");
        configure(32'h4000, mk_ctl(1, 0, 8'hFF, 0));
        check_access(32'h4000, 2'd3, 1'b1, 1'b0, 1'b0, "R2");
        // R3: access-type filter
        configure(32'h4000, mk_ctl(1, 1, 8'hFF, 0));
        check_access(32'h4000, 2'd0, 1'b0, 1'b0, 1'b1, "R3");
        check_access(32'h4000, 2'd0, 1'b1, 1'b0, 1'b0, "R3");
        configure(32'h4000, mk_ctl(1, 2, 8'hFF, 0));
        check_access(32'h4000, 2'd0, 1'b0, 1'b0, 1'b0, "R3");
        check_access(32'h4000, 2'd0, 1'b1, 1'b0, 1'b1, "R3");
        // R4: reserved mask exponents
        configure(32'h4000, mk_ctl(1, 3, 8'hFF, 1));
        check_access(32'h4000, 2'd0, 1'b0, 1'b0, 1'b0, "R4");
        configure(32'h4000, mk_ctl(1, 3, 8'hFF, 2));
        check_access(32'h4000, 2'd0, 1'b0, 1'b0, 1'b0, "R4");
        // R5: power-of-two range, base aligned down
        configure(32'h4123, mk_ctl(1, 3, 8'h00, 8));
        check_access(32'h4100, 2'd0, 1'b0, 1'b0, 1'b1, "R5");
        check_access(32'h41FF, 2'd0, 1'b0, 1'b0, 1'b1, "R5");
        check_access(32'h4200, 2'd0, 1'b0, 1'b0, 1'b0, "R5");
        check_access(32'h40FF, 2'd0, 1'b0, 1'b0, 1'b0, "R5");
        // R6: bit 2 keeps low select nibble
        configure(32'h4004, mk_ctl(1, 3, 8'hF0, 0));
        check_access(32'h4004, 2'd3, 1'b0, 1'b0, 1'b0, "R6");
        configure(32'h4004, mk_ctl(1, 3, 8'h12, 0));
        check_access(32'h4005, 2'd0, 1'b0, 1'b0, 1'b1, "R6");
        check_access(32'h4008, 2'd0, 1'b0, 1'b0, 1'b0, "R6");
        // R7: first run of ones only
        configure(32'h4000, mk_ctl(1, 3, 8'hB6, 0));
        check_access(32'h4000, 2'd0, 1'b0, 1'b0, 1'b0, "R7");
        check_access(32'h4002, 2'd0, 1'b0, 1'b0, 1'b1, "R7");
        check_access(32'h4004, 2'd0, 1'b0, 1'b0, 1'b0, "R7");
        // R9: partial overlap from below
        check_access(32'h3FFC, 2'd3, 1'b0, 1'b0, 1'b1, "R9");
        // R11: access during write and decode cycles is ignored
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = 1'b0; cfg_wdata = 32'h4000;
        acc_valid = 1'b1; acc_addr = 32'h4002; acc_size = 2'd0; acc_write = 1'b0; acc_big_endian = 1'b0;
        @(negedge clk);
        cfg_we = 1'b0;
        checks++;
        if (hit !== 1'b0) begin fails++; $display("FAIL R11 write-cycle hit=%b expected 0", hit); end
        @(negedge clk);
        acc_valid = 1'b0;
        checks++;
        if (hit !== 1'b0) begin fails++; $display("FAIL R11 decode-cycle hit=%b expected 0", hit); end
        check_access(32'h4002, 2'd0, 1'b0, 1'b0, 1'b1, "R11");

        // random configurations
        for (int k = 0; k < 60; k++) begin
            logic [31:0] v, c;
            v = 32'h4000 + $urandom_range(0, 255);
            c = mk_ctl(($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)),
                       8'($urandom), ($urandom_range(0, 1) != 0) ? 5'd0 : 5'($urandom_range(0, 12)));
            configure(v, c);
            for (int j = 0; j < 25; j++) begin
                model_access(32'h3FF0 + $urandom_range(0, 300), 2'($urandom_range(0, 3)),
                             1'($urandom), 1'($urandom), "R9 random");
            end
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule